// File: doc/BRIEF.md
# Accumulator Machine Execution Core

This block runs programs for a small 24-bit accumulator machine. It works in several cycles per instruction. It fetches each 3-byte instruction from a byte-wide synchronous memory, one byte per cycle, and forms a 15-bit target address. That address is either taken straight from the instruction or offset by the index register. The core then reads or writes one 24-bit operand word, again one byte per cycle, and updates the accumulator, the index, the link register, the program counter or the condition code.

Byte-wide device traffic goes through a separate port. A test instruction samples the device's ready line. A read waits for the device to offer a byte. A write holds a byte out until the device takes it. An opcode outside the table stops the core for good, and the core then shows it on the halt output.

The memory returns read data one cycle after the address is presented and takes a write on the clock edge where the write enable is high. Words are stored big-endian: the lowest address holds the most significant byte.

Top module: `acc_core`

## Requirements
- R1: While reset is low, and right after it is released, all registers are zero: the accumulator, the index, the link, the program counter and the condition code. Fetching starts at byte address 0 and steps through 0, 1, 2. halt, mem_we, dev_rd_req and dev_wr_valid are all low.
- R2: An instruction is three bytes read from PC, PC+1 and PC+2. Bits [23:16] are the opcode, bit 15 is the index flag and bits [14:0] are the address field. PC advances by 3 before the instruction executes.
- R3: A word is the three bytes at TA, TA+1 and TA+2, most significant first. The loads are 0x00 (accumulator), 0x04 (index) and 0x08 (link). The matching stores are 0x0C, 0x10 and 0x14. A store writes the three bytes on consecutive cycles at rising addresses.
- R4: With the index flag at 0, TA is the address field. With the flag at 1, TA is the address field plus the low 15 bits of the index register, modulo 32768.
- R5: 0x18 (add), 0x1C (subtract) and 0x20 (multiply) combine the accumulator with the memory word as two's complement numbers. The low 24 bits of the result go to the accumulator.
- R6: 0x28 compares the accumulator with the memory word as signed numbers. It writes the condition code SW[7:6] as 00 for less, 01 for equal and 10 for greater. 0x38 jumps to TA on less, 0x30 on equal and 0x34 on greater. 0x3C always jumps. A jump that is not taken falls through to the next instruction.
- R7: 0x48 (call) copies the advanced PC into the link register and jumps to TA. 0x4C (return) loads PC from the link register.
- R8: 0xE0 (device test) sets the condition code to 00 when dev_ready is high and to 01 when it is low.
- R9: 0xD8 (device read) raises dev_rd_req until a cycle with dev_valid high. In that cycle dev_rdata goes into accumulator bits [7:0]. Bits [23:8] are left unchanged.
- R10: 0xDC (device write) raises dev_wr_valid with dev_wdata equal to accumulator bits [7:0]. Both stay unchanged until a cycle with dev_ready high, which completes the transfer. Exactly one byte is accepted per instruction.
- R11: Any opcode not listed above (0xFF, for example) raises halt. halt then stays high until reset. No later instruction runs, and mem_we stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 15 | Byte address to memory |
| mem_rdata | input | 8 | Read byte, valid one cycle after its address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable for mem_addr and mem_wdata |
| dev_ready | input | 1 | Device ready, sampled by test and by write |
| dev_valid | input | 1 | Device offers a byte on dev_rdata |
| dev_rdata | input | 8 | Byte from device |
| dev_rd_req | output | 1 | Core waits for a device byte |
| dev_wr_valid | output | 1 | Core offers dev_wdata to the device |
| dev_wdata | output | 8 | Byte to device |
| halt | output | 1 | Core stopped on an unknown opcode |

## Verification
The assertions check several properties on every cycle:
- halt stays high once it is raised, and no write happens while halted;
- the bytes of a store go to consecutive addresses;
- PC has moved by exactly three when an instruction is decoded;
- a pending device write keeps its byte steady;
- a device read leaves the upper accumulator bits untouched;
- the condition code never takes its unused value.

Arithmetic results, signed compare outcomes, branch selection, index offsets, call and return linkage, and the bytes moved over the device port can only be shown by the bench's programs. It leaves their results in memory, or counts them at the device port.

// File: rtl/acc_pkg.sv
// Shared definitions for the accumulator core: opcode table, condition
// codes, control states and ALU selects. Assumes 8-bit opcodes.
package acc_pkg;

    localparam int OP_W = 8;

    localparam logic [7:0] OP_LDA  = 8'h00;
    localparam logic [7:0] OP_LDX  = 8'h04;
    localparam logic [7:0] OP_LDL  = 8'h08;
    localparam logic [7:0] OP_STA  = 8'h0C;
    localparam logic [7:0] OP_STX  = 8'h10;
    localparam logic [7:0] OP_STL  = 8'h14;
    localparam logic [7:0] OP_ADD  = 8'h18;
    localparam logic [7:0] OP_SUB  = 8'h1C;
    localparam logic [7:0] OP_MUL  = 8'h20;
    localparam logic [7:0] OP_CMP  = 8'h28;
    localparam logic [7:0] OP_JEQ  = 8'h30;
    localparam logic [7:0] OP_JGT  = 8'h34;
    localparam logic [7:0] OP_JLT  = 8'h38;
    localparam logic [7:0] OP_JMP  = 8'h3C;
    localparam logic [7:0] OP_CALL = 8'h48;
    localparam logic [7:0] OP_RET  = 8'h4C;
    localparam logic [7:0] OP_DRD  = 8'hD8;
    localparam logic [7:0] OP_DWR  = 8'hDC;
    localparam logic [7:0] OP_DTST = 8'hE0;

    localparam logic [1:0] CC_LT = 2'b00;
    localparam logic [1:0] CC_EQ = 2'b01;
    localparam logic [1:0] CC_GT = 2'b10;

    typedef enum logic [2:0] {
        S_FETCH, S_DECODE, S_READ, S_EXEC, S_WRITE, S_DEVRD, S_DEVWR, S_HALT
    } state_t;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_MUL} alu_sel_t;

endpackage

// File: rtl/acc_agen.sv
// Target address generator: address field, offset by the index register
// when the index flag is set. Assumes the sum wraps modulo 2**ADDR_W.
module acc_agen #(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] field,
    input  logic              idx_en,
    input  logic [ADDR_W-1:0] idx,
    output logic [ADDR_W-1:0] target
);
    // Form the target address.
    always_comb begin
        target = field + (idx_en ? idx : '0);
    end
endmodule

// File: rtl/acc_alu.sv
// Arithmetic unit: add, subtract, low half of multiply, and a signed
// compare code. Assumes two's complement operands of width W.
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = 24
) (
    input  alu_sel_t       sel,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic [1:0]     cc
);
    logic [2*W-1:0] prod;

    // Select the arithmetic result; product truncated to W bits.
    always_comb begin
        prod = a * b;
        case (sel)
            ALU_SUB: res = a - b;
            ALU_MUL: res = prod[W-1:0];
            default: res = a + b;
        endcase
    end

    // Signed three-way comparison of a against b.
    always_comb begin
        if ($signed(a) < $signed(b))
            cc = CC_LT;
        else if (a == b)
            cc = CC_EQ;
        else
            cc = CC_GT;
    end
endmodule

// File: rtl/acc_core.sv
// Multi-cycle accumulator core. Fetches 3-byte instructions a byte per
// cycle from a memory with one-cycle read latency, moves big-endian words
// a byte per cycle, and runs device test/read/write over a ready/valid
// port. Assumes WORD_W == 8 + 1 + ADDR_W and WORD_W a multiple of 8.
module acc_core
    import acc_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic              dev_ready,
    input  logic              dev_valid,
    input  logic [7:0]        dev_rdata,
    output logic              dev_rd_req,
    output logic              dev_wr_valid,
    output logic [7:0]        dev_wdata,
    output logic              halt
);
    localparam int BYTES = WORD_W / 8;
    localparam int CNT_W = $clog2(BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTES);
    localparam logic [CNT_W-1:0] CNT_WEND = CNT_W'(BYTES - 1);

    state_t            state;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] acc, xr, lr, pc, ir, opnd, wbuf;
    logic [1:0]        cc;
    logic [ADDR_W-1:0] ta;

    logic [7:0]        op;
    logic              xflag;
    logic [ADDR_W-1:0] afield, ta_calc;
    alu_sel_t          asel;
    logic [WORD_W-1:0] alu_res;
    logic [1:0]        alu_cc;

    // Split the instruction register into its fields.
    always_comb begin
        op     = ir[WORD_W-1 -: OP_W];
        xflag  = ir[ADDR_W];
        afield = ir[ADDR_W-1:0];
    end

    acc_agen #(.ADDR_W(ADDR_W)) u_agen (
        .field (afield),
        .idx_en(xflag),
        .idx   (xr[ADDR_W-1:0]),
        .target(ta_calc)
    );

    // Pick the ALU operation from the opcode.
    always_comb begin
        case (op)
            OP_SUB:  asel = ALU_SUB;
            OP_MUL:  asel = ALU_MUL;
            default: asel = ALU_ADD;
        endcase
    end

    acc_alu #(.W(WORD_W)) u_alu (
        .sel(asel),
        .a  (acc),
        .b  (opnd),
        .res(alu_res),
        .cc (alu_cc)
    );

    // Drive the memory and device ports from the control state.
    always_comb begin
        mem_addr     = (state == S_FETCH) ? pc[ADDR_W-1:0] + ADDR_W'(cnt)
                                          : ta + ADDR_W'(cnt);
        mem_we       = (state == S_WRITE);
        mem_wdata    = wbuf[WORD_W-1 -: 8];
        dev_rd_req   = (state == S_DEVRD);
        dev_wr_valid = (state == S_DEVWR);
        dev_wdata    = acc[7:0];
        halt         = (state == S_HALT);
    end

    // Sequencer: fetch, decode, operand access, execute, device waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FETCH;
            cnt   <= '0;
            acc   <= '0;
            xr    <= '0;
            lr    <= '0;
            pc    <= '0;
            ir    <= '0;
            opnd  <= '0;
            wbuf  <= '0;
            cc    <= CC_LT;
            ta    <= '0;
        end else begin
            case (state)
                S_FETCH: begin
                    if (cnt != '0) ir <= {ir[WORD_W-9:0], mem_rdata};
                    if (cnt == CNT_LAST) begin
                        cnt   <= '0;
                        pc    <= pc + WORD_W'(BYTES);
                        state <= S_DECODE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_DECODE: begin
                    ta    <= ta_calc;
                    state <= S_FETCH;
                    case (op)
                        OP_LDA, OP_LDX, OP_LDL, OP_ADD, OP_SUB, OP_MUL, OP_CMP:
                            state <= S_READ;
                        OP_STA: begin wbuf <= acc; state <= S_WRITE; end
                        OP_STX: begin wbuf <= xr;  state <= S_WRITE; end
                        OP_STL: begin wbuf <= lr;  state <= S_WRITE; end
                        OP_JMP: pc <= WORD_W'(ta_calc);
                        OP_JEQ: if (cc == CC_EQ) pc <= WORD_W'(ta_calc);
                        OP_JGT: if (cc == CC_GT) pc <= WORD_W'(ta_calc);
                        OP_JLT: if (cc == CC_LT) pc <= WORD_W'(ta_calc);
                        OP_CALL: begin
                            lr <= pc;
                            pc <= WORD_W'(ta_calc);
                        end
                        OP_RET:  pc <= lr;
                        OP_DTST: cc <= dev_ready ? CC_LT : CC_EQ;
                        OP_DRD:  state <= S_DEVRD;
                        OP_DWR:  state <= S_DEVWR;
                        default: state <= S_HALT;
                    endcase
                end
                S_READ: begin
                    if (cnt != '0) opnd <= {opnd[WORD_W-9:0], mem_rdata};
                    if (cnt == CNT_LAST) begin
                        cnt   <= '0;
                        state <= S_EXEC;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_EXEC: begin
                    case (op)
                        OP_LDA:  acc <= opnd;
                        OP_LDX:  xr  <= opnd;
                        OP_LDL:  lr  <= opnd;
                        OP_CMP:  cc  <= alu_cc;
                        default: acc <= alu_res;
                    endcase
                    state <= S_FETCH;
                end
                S_WRITE: begin
                    wbuf <= wbuf << 8;
                    if (cnt == CNT_WEND) begin
                        cnt   <= '0;
                        state <= S_FETCH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_DEVRD: begin
                    if (dev_valid) begin
                        acc[7:0] <= dev_rdata;
                        state    <= S_FETCH;
                    end
                end
                S_DEVWR: begin
                    if (dev_ready) state <= S_FETCH;
                end
                default: state <= S_HALT;
            endcase
        end
    end

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    // R11
    halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !mem_we);

    // R3
    store_addr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + 1'b1);

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE) |-> pc == $past(pc) + WORD_W'(BYTES));

    // R10
    dev_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr_valid && !dev_ready) |=> (dev_wr_valid && $stable(dev_wdata)));

    // R9
    dev_rd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEVRD) |=> acc[WORD_W-1:8] == $past(acc[WORD_W-1:8]));

    // R6
    cc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc != 2'b11);

endmodule

// File: tb/test_acc_core.sv
// Directed bench for acc_core: small programs in a bench memory, results
// read back from memory and from the device port after halt.
module test_acc_core;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 4096;
    localparam int RUN_LIMIT  = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        dev_ready = 1'b0;
    logic        dev_valid = 1'b0;
    logic [7:0]  dev_rdata = 8'h5A;
    logic        dev_rd_req, dev_wr_valid, halt;
    logic [7:0]  dev_wdata;

    logic [7:0]  mem [0:MEM_BYTES-1];
    logic        ld_en = 1'b0;
    logic        ld_clr = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit td_mode = 1'b0;
    bit td_level = 1'b0;
    int rd_wait = 0;
    int wr_wait = 0;
    int wd_count = 0;
    logic [7:0] wd_byte = '0;
    int halt_writes = 0;
    bit wd_unstable = 1'b0;
    int wd_stall = 0;

    acc_core i_acc_core (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we),
        .dev_ready(dev_ready), .dev_valid(dev_valid), .dev_rdata(dev_rdata),
        .dev_rd_req(dev_rd_req), .dev_wr_valid(dev_wr_valid),
        .dev_wdata(dev_wdata), .halt(halt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Synchronous memory with one-cycle read latency and a loader port.
    always @(posedge clk) begin
        if (ld_clr) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
        end else if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr[11:0]];
    end

    // Device model, updated away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_wait = 0; wr_wait = 0; dev_valid = 1'b0;
            dev_ready = td_mode ? td_level : 1'b0;
        end else begin
            rd_wait   = dev_rd_req ? rd_wait + 1 : 0;
            dev_valid = dev_rd_req && (rd_wait >= 4);
            if (dev_wr_valid && !dev_ready) begin
                wd_stall++;
                if (dev_wdata != 8'h5A) wd_unstable = 1'b1;
            end
            wr_wait   = dev_wr_valid ? wr_wait + 1 : 0;
            dev_ready = td_mode ? td_level : (dev_wr_valid && (wr_wait >= 3));
        end
    end

    // Record accepted device bytes and writes made while halted.
    always @(posedge clk) begin
        if (!rst_n) begin
            wd_count <= 0; halt_writes <= 0;
        end else begin
            if (dev_wr_valid && dev_ready) begin
                wd_count <= wd_count + 1;
                wd_byte  <= dev_wdata;
            end
            if (halt && mem_we) halt_writes <= halt_writes + 1;
        end
    end

    // Watchdog: a hung run ends as a failure with the summary line.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] word_at(input int a);
        return {mem[a], mem[a+1], mem[a+2]};
    endfunction

    task automatic put(input int a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 12'(a); ld_data = d;
    endtask

    task automatic put_word(input int a, input logic [23:0] w);
        put(a, w[23:16]); put(a + 1, w[15:8]); put(a + 2, w[7:0]);
    endtask

    task automatic ins(input int a, input logic [7:0] op, input bit x, input int ad);
        put_word(a, {op, x, 15'(ad)});
    endtask

    task automatic begin_load();
        @(negedge clk);
        rst_n = 1'b0;
        ld_clr = 1'b1;
        @(negedge clk);
        ld_clr = 1'b0;
    endtask

    task automatic run(input string tag);
        int n;
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!halt && n < RUN_LIMIT) begin
            @(negedge clk);
            n++;
        end
        check({tag, " run reaches halt"}, 24'(halt), 24'd1);
    endtask

    // R1: reset values and first fetch addresses.
    task automatic t_reset();
        begin_load();
        ins(0, 8'h0C, 0, 'h100);
        ins(3, 8'h10, 0, 'h103);
        ins(6, 8'h14, 0, 'h106);
        ins(9, 8'hFF, 0, 0);
        put_word('h100, 24'hEEEEEE);
        put_word('h103, 24'hEEEEEE);
        put_word('h106, 24'hEEEEEE);
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        check("R1 addr in reset", 24'(mem_addr), 24'd0);
        check("R1 halt/we/dev in reset",
              24'({halt, mem_we, dev_rd_req, dev_wr_valid}), 24'd0);
        rst_n = 1'b1;
        check("R1 first fetch addr", 24'(mem_addr), 24'd0);
        @(negedge clk);
        check("R1 second fetch addr", 24'(mem_addr), 24'd1);
        @(negedge clk);
        check("R1 third fetch addr", 24'(mem_addr), 24'd2);
        for (int i = 0; i < RUN_LIMIT && !halt; i++) @(negedge clk);
        check("R1 accumulator zero", word_at('h100), 24'h0);
        check("R1 index zero", word_at('h103), 24'h0);
        check("R1 link zero", word_at('h106), 24'h0);
    endtask

    // R2 R3 R5: load, add/sub/mul, store.
    task automatic t_arith(input logic [23:0] a, input logic [23:0] b);
        logic [47:0] p;
        begin_load();
        ins(0,  8'h00, 0, 'h100); ins(3,  8'h18, 0, 'h103); ins(6,  8'h0C, 0, 'h110);
        ins(9,  8'h00, 0, 'h100); ins(12, 8'h1C, 0, 'h103); ins(15, 8'h0C, 0, 'h113);
        ins(18, 8'h00, 0, 'h100); ins(21, 8'h20, 0, 'h103); ins(24, 8'h0C, 0, 'h116);
        ins(27, 8'hFF, 0, 0);
        put_word('h100, a); put_word('h103, b);
        run("R2");
        p = 48'(a) * 48'(b);
        check("R5 add", word_at('h110), 24'(a + b));
        check("R5 sub", word_at('h113), 24'(a - b));
        check("R5 mul low bits", word_at('h116), p[23:0]);
        check("R3 operand untouched", word_at('h100), a);
    endtask

    // R4: indexed load and store.
    task automatic t_index();
        begin_load();
        ins(0,  8'h04, 0, 'h180);
        ins(3,  8'h00, 1, 'h200);
        ins(6,  8'h0C, 1, 'h240);
        ins(9,  8'h0C, 0, 'h250);
        ins(12, 8'hFF, 0, 0);
        put_word('h180, 24'h000006);
        put_word('h200, 24'h111111); put_word('h203, 24'h222222);
        put_word('h206, 24'h333333);
        run("R4");
        check("R4 indexed store", word_at('h246), 24'h333333);
        check("R4 direct store", word_at('h250), 24'h333333);
        check("R4 unindexed slot empty", word_at('h240), 24'h000000);
    endtask

    // R6: signed compare and conditional jumps.
    task automatic t_cmp(input logic [23:0] a, input logic [23:0] b, input logic [23:0] exp);
        begin_load();
        ins(0,  8'h00, 0, 'h100); ins(3,  8'h28, 0, 'h103);
        ins(6,  8'h38, 0, 'h30);  ins(9,  8'h30, 0, 'h40);
        ins(12, 8'h34, 0, 'h50);  ins(15, 8'hFF, 0, 0);
        ins('h30, 8'h00, 0, 'h110); ins('h33, 8'h0C, 0, 'h120); ins('h36, 8'hFF, 0, 0);
        ins('h40, 8'h00, 0, 'h113); ins('h43, 8'h0C, 0, 'h120); ins('h46, 8'hFF, 0, 0);
        ins('h50, 8'h00, 0, 'h116); ins('h53, 8'h0C, 0, 'h120); ins('h56, 8'hFF, 0, 0);
        put_word('h100, a); put_word('h103, b);
        put_word('h110, 24'd1); put_word('h113, 24'd2); put_word('h116, 24'd3);
        run("R6");
        check("R6 branch path taken", word_at('h120), exp);
    endtask

    // R7 R6: call, return, unconditional jump.
    task automatic t_call();
        begin_load();
        ins(0,  8'h48, 0, 'h40);
        ins(3,  8'h0C, 0, 'h120);
        ins(6,  8'h3C, 0, 'h60);
        ins(9,  8'h0C, 0, 'h130);
        ins(12, 8'hFF, 0, 0);
        ins('h40, 8'h00, 0, 'h110);
        ins('h43, 8'h4C, 0, 0);
        ins('h60, 8'h14, 0, 'h123);
        ins('h63, 8'hFF, 0, 0);
        put_word('h110, 24'hC0FFEE);
        put_word('h130, 24'hEEEEEE);
        run("R7");
        check("R7 subroutine ran and returned", word_at('h120), 24'hC0FFEE);
        check("R7 link holds return address", word_at('h123), 24'h000003);
        check("R6 unconditional jump skipped store", word_at('h130), 24'hEEEEEE);
    endtask

    // R8: device test sets the condition code.
    task automatic t_dtest(input bit lvl, input logic [23:0] exp);
        td_mode = 1'b1; td_level = lvl;
        begin_load();
        ins(0, 8'hE0, 0, 0);
        ins(3, 8'h38, 0, 'h30);
        ins(6, 8'h30, 0, 'h40);
        ins(9, 8'hFF, 0, 0);
        ins('h30, 8'h00, 0, 'h110); ins('h33, 8'h0C, 0, 'h120); ins('h36, 8'hFF, 0, 0);
        ins('h40, 8'h00, 0, 'h113); ins('h43, 8'h0C, 0, 'h120); ins('h46, 8'hFF, 0, 0);
        put_word('h110, 24'd1); put_word('h113, 24'd2);
        run("R8");
        check("R8 test result branch", word_at('h120), exp);
        td_mode = 1'b0;
    endtask

    // R9 R10: device read then device write.
    task automatic t_dio();
        wd_unstable = 1'b0; wd_stall = 0;
        begin_load();
        ins(0, 8'h00, 0, 'h100);
        ins(3, 8'hD8, 0, 0);
        ins(6, 8'h0C, 0, 'h110);
        ins(9, 8'hDC, 0, 0);
        ins(12, 8'hFF, 0, 0);
        put_word('h100, 24'hABCD12);
        run("R9");
        check("R9 low byte from device, upper kept", word_at('h110), 24'hABCD5A);
        check("R10 one byte accepted", 24'(wd_count), 24'd1);
        check("R10 accepted byte", 24'(wd_byte), 24'h00005A);
        check("R10 held while stalled", 24'({wd_unstable, wd_stall >= 2}), 24'd1);
    endtask

    // R11: unknown opcode halts for good.
    task automatic t_halt();
        begin_load();
        ins(0, 8'h00, 0, 'h110);
        ins(3, 8'hFF, 0, 0);
        ins(6, 8'h0C, 0, 'h120);
        ins(9, 8'hFF, 0, 0);
        put_word('h110, 24'h123456);
        run("R11");
        for (int i = 0; i < 40; i++) @(negedge clk);
        check("R11 halt stays high", 24'(halt), 24'd1);
        check("R11 later store not run", word_at('h120), 24'h000000);
        check("R11 no writes while halted", 24'(halt_writes), 24'd0);
    endtask

    initial begin
        t_reset();
        t_arith(24'h7FFFFF, 24'h000002);
        t_arith(24'hFFFFFD, 24'h000005);
        t_index();
        t_cmp(24'hFFFFFF, 24'h000001, 24'd1);
        t_cmp(24'h000005, 24'h000005, 24'd2);
        t_cmp(24'h000001, 24'hFFFFFF, 24'd3);
        t_call();
        t_dtest(1'b1, 24'd1);
        t_dtest(1'b0, 24'd2);
        t_dio();
        t_halt();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule